// File: doc/BRIEF.md
# Switch-Configured Memory Bank Decoder

This block decodes bus cycles for a 32 KB static RAM card on a microcomputer bus with a 16-bit address and 8-bit data. The card's storage is split into three banks: two small banks of 8 KB, called A and B, and one large bank of 16 KB, called C. Static configuration inputs place each bank independently in the 64 KB address space. Other configuration inputs switch each bank off or protect it from writes.

For every bus cycle the decoder produces one chip-select per bank, a gated write strobe for the RAM array, and a read-data output enable for the card's bus drivers. An access is offered with `bus_valid`, and the card answers on `bus_ready`. A cycle completes on a clock edge where both are high. While `bus_ready` is low the master must hold the address, the direction and the strobe steady. When a wait state is configured, every access that hits the card is held off for one clock. A phantom input from elsewhere on the bus silences the card, so that another resource can take over the same addresses.

All decoding is combinational from the address and the configuration. The only stored state is the flag that tracks the wait state.

Top module: `ramcard_decoder`

## Requirements
- R1: Bank A matches when address bits 15:13 equal `cfg_base_a`. For example, 3'b000 places it at 0x0000–0x1FFF.
- R2: Bank B matches when address bits 15:13 equal `cfg_base_b`, on any 8 KB boundary.
- R3: Bank C matches when address bits 15:14 equal `cfg_base_c`. For example, 2'b10 places it at 0x8000–0xBFFF.
- R4: A bank whose disable input (`cfg_dis_a`, `cfg_dis_b`, `cfg_dis_c`) is high never asserts its chip-select, for reads or for writes.
- R5: When enabled banks overlap, A wins over B and B wins over C, so at most one chip-select is high at any time.
- R6: `mem_we` is asserted only when the selected region is write-enabled. The region enable is `cfg_we_a` for A and `cfg_we_b` for B. For C it is `cfg_we_cl` when address bit 13 is 0 and `cfg_we_ch` when address bit 13 is 1.
- R7: Write protection has no effect on reads: a protected bank still asserts its chip-select and `card_oe`.
- R8: While `phantom` is high, no chip-select, `card_oe` or `mem_we` is asserted.
- R9: `card_oe` is high exactly when some chip-select is high and `bus_write` is low.
- R10: With `cfg_wait` low, `bus_ready` is always high. With `cfg_wait` high, `bus_ready` is low for the first clock of every access that hits the card and high on the following clock. Accesses that miss the card are not delayed.
- R11: `mem_we` is asserted only on the completing clock of a write cycle, when `bus_valid`, `bus_ready`, `bus_write` and `bus_wstb` are all high.
- R12: While `bus_valid` is low, no chip-select, `card_oe` or `mem_we` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Address of the current cycle |
| bus_valid | input | 1 | A bus cycle is offered |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_wstb | input | 1 | Bus write data strobe |
| phantom | input | 1 | Another resource claims this address |
| cfg_base_a | input | 3 | Base of bank A (address bits 15:13) |
| cfg_base_b | input | 3 | Base of bank B (address bits 15:13) |
| cfg_base_c | input | 2 | Base of bank C (address bits 15:14) |
| cfg_dis_a | input | 1 | Turn bank A off |
| cfg_dis_b | input | 1 | Turn bank B off |
| cfg_dis_c | input | 1 | Turn bank C off |
| cfg_we_a | input | 1 | Allow writes to bank A |
| cfg_we_b | input | 1 | Allow writes to bank B |
| cfg_we_cl | input | 1 | Allow writes to the lower half of bank C |
| cfg_we_ch | input | 1 | Allow writes to the upper half of bank C |
| cfg_wait | input | 1 | Insert one wait state on card hits |
| cs_a | output | 1 | Chip-select for bank A |
| cs_b | output | 1 | Chip-select for bank B |
| cs_c | output | 1 | Chip-select for bank C |
| mem_we | output | 1 | Write strobe to the RAM array |
| card_oe | output | 1 | Read data drive enable |
| bus_ready | output | 1 | Card accepts the cycle this clock |

## Verification
The assertions check the following on every cycle:
- no more than one chip-select is high;
- nothing is asserted under phantom or when the bus is idle;
- a disabled bank A stays silent;
- `mem_we` only appears on a completing write with the strobe high;
- `card_oe` only appears on reads;
- a stall never lasts longer than one clock, and there are no stalls at all while the wait state is off.

Only the bench's scenarios can show the rest. This covers each bank landing at the right address for every base value, the effect of each write-enable bit on each bank half, and the outcome when banks overlap. It also covers the exact cycle on which a wait state ends and the fact that back-to-back hits are each stretched again.

// File: rtl/ramcard_pkg.sv
package ramcard_pkg;

  // Which bank owns the current address after priority resolution.
  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_A    = 2'd1,
    BANK_B    = 2'd2,
    BANK_C    = 2'd3
  } bank_id_e;

endpackage

// File: rtl/bank_match.sv
// Compares the top address bits against a bank's base selection.
module bank_match #(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] addr_hi,
  input  logic [SEL_W-1:0] base,
  input  logic             bank_off,
  output logic             match
);

  always_comb begin
    match = !bank_off && (addr_hi == base);
  end

endmodule

// File: rtl/bank_priority.sv
// Resolves overlapping matches: A over B, B over C.
module bank_priority
  import ramcard_pkg::*;
(
  input  logic     match_a,
  input  logic     match_b,
  input  logic     match_c,
  output bank_id_e winner
);

  always_comb begin
    if (match_a)      winner = BANK_A;
    else if (match_b) winner = BANK_B;
    else if (match_c) winner = BANK_C;
    else              winner = BANK_NONE;
  end

endmodule

// File: rtl/ramcard_wait.sv
// One-clock stall on every card hit when enabled.
module ramcard_wait (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic wait_en,
  output logic ready
);

  logic waited_q;
  logic stall;

  always_comb begin
    stall = wait_en && hit && !waited_q;
    ready = !stall;
  end

  // The flag marks that the stall for the present access was served. It
  // clears on the clock after completion, so the next access stalls again.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) waited_q <= 1'b0;
    else        waited_q <= stall;
  end

endmodule

// File: rtl/ramcard_decoder.sv
module ramcard_decoder
  import ramcard_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SMALL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_wstb,
  input  logic               phantom,
  input  logic [SMALL_W-1:0] cfg_base_a,
  input  logic [SMALL_W-1:0] cfg_base_b,
  input  logic [SMALL_W-2:0] cfg_base_c,
  input  logic               cfg_dis_a,
  input  logic               cfg_dis_b,
  input  logic               cfg_dis_c,
  input  logic               cfg_we_a,
  input  logic               cfg_we_b,
  input  logic               cfg_we_cl,
  input  logic               cfg_we_ch,
  input  logic               cfg_wait,
  output logic               cs_a,
  output logic               cs_b,
  output logic               cs_c,
  output logic               mem_we,
  output logic               card_oe,
  output logic               bus_ready
);

  // The large bank is twice a small bank, so its base field is one bit shorter.
  localparam int LARGE_W  = SMALL_W - 1;
  // Lowest address bit that selects a small bank; it splits bank C in two.
  localparam int HALF_BIT = ADDR_W - SMALL_W;

  logic [SMALL_W-1:0] small_base [2];
  logic [1:0]         small_off;
  logic [1:0]         small_hit;
  logic               large_hit;
  bank_id_e           winner;
  logic               access_live;
  logic               hit;
  logic               region_we;
  logic               unused_addr_bits;

  assign unused_addr_bits = ^bus_addr[HALF_BIT-1:0];

  assign small_base[0] = cfg_base_a;
  assign small_base[1] = cfg_base_b;
  assign small_off     = {cfg_dis_b, cfg_dis_a};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_small
      bank_match #(.SEL_W(SMALL_W)) u_match (
        .addr_hi  (bus_addr[ADDR_W-1 -: SMALL_W]),
        .base     (small_base[i]),
        .bank_off (small_off[i]),
        .match    (small_hit[i])
      );
    end
  endgenerate

  bank_match #(.SEL_W(LARGE_W)) u_large (
    .addr_hi  (bus_addr[ADDR_W-1 -: LARGE_W]),
    .base     (cfg_base_c),
    .bank_off (cfg_dis_c),
    .match    (large_hit)
  );

  bank_priority u_pri (
    .match_a (small_hit[0]),
    .match_b (small_hit[1]),
    .match_c (large_hit),
    .winner  (winner)
  );

  always_comb begin
    access_live = bus_valid && !phantom;
    cs_a = access_live && (winner == BANK_A);
    cs_b = access_live && (winner == BANK_B);
    cs_c = access_live && (winner == BANK_C);
    hit  = cs_a || cs_b || cs_c;
    unique case (winner)
      BANK_A:  region_we = cfg_we_a;
      BANK_B:  region_we = cfg_we_b;
      BANK_C:  region_we = bus_addr[HALF_BIT] ? cfg_we_ch : cfg_we_cl;
      default: region_we = 1'b0;
    endcase
  end

  ramcard_wait u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .wait_en (cfg_wait),
    .ready   (bus_ready)
  );

  always_comb begin
    mem_we  = hit && bus_write && bus_wstb && region_we && bus_ready;
    card_oe = hit && !bus_write;
  end

endmodule

// File: rtl/ramcard_decoder_chk.sv
module ramcard_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_valid,
  input logic bus_write,
  input logic bus_wstb,
  input logic phantom,
  input logic cfg_dis_a,
  input logic cfg_wait,
  input logic cs_a,
  input logic cs_b,
  input logic cs_c,
  input logic mem_we,
  input logic card_oe,
  input logic bus_ready
);

  // R5
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_a, cs_b, cs_c}));

  // R8
  phantom_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phantom |-> !(cs_a || cs_b || cs_c || card_oe || mem_we));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !(cs_a || cs_b || cs_c || card_oe || mem_we));

  // R4
  dis_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dis_a |-> !cs_a);

  // R11
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bus_valid && bus_ready && bus_write && bus_wstb));

  // R9
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_oe |-> (!bus_write && (cs_a || cs_b || cs_c)));

  // R10
  no_wait_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wait |-> bus_ready);

  // R10
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> bus_ready);

endmodule

bind ramcard_decoder ramcard_decoder_chk u_chk (.*);

// File: tb/sim_ramcard_decoder.sv
module sim_ramcard_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wstb = 1'b0, phantom = 1'b0;
  logic [2:0]  cfg_base_a = '0, cfg_base_b = '0;
  logic [1:0]  cfg_base_c = '0;
  logic        cfg_dis_a = 1'b0, cfg_dis_b = 1'b0, cfg_dis_c = 1'b0;
  logic        cfg_we_a = 1'b0, cfg_we_b = 1'b0, cfg_we_cl = 1'b0, cfg_we_ch = 1'b0;
  logic        cfg_wait = 1'b0;
  logic        cs_a, cs_b, cs_c, mem_we, card_oe, bus_ready;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  ramcard_decoder u0 (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at addr %h: actual %b expected %b", tag, bus_addr, act, exp);
    end
  endtask

  // Reference selection {c,b,a} from address arithmetic and priority order.
  function automatic logic [2:0] exp_sel(input logic [15:0] a);
    logic ma, mb, mc;
    ma = !cfg_dis_a && ((a >> 13) == cfg_base_a);
    mb = !cfg_dis_b && ((a >> 13) == cfg_base_b);
    mc = !cfg_dis_c && ((a >> 14) == cfg_base_c);
    if (!bus_valid || phantom) return 3'b000;
    if (ma) return 3'b001;
    if (mb) return 3'b010;
    if (mc) return 3'b100;
    return 3'b000;
  endfunction

  function automatic logic [15:0] probe(input int k);
    return 16'(k * 16'h1000 + 16'h00A5 + k);
  endfunction

  task automatic drive_addr(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [2:0] e;
    logic       we_exp;
    repeat (3) @(posedge clk);
    #1;
    // Reset state
    chk("R12 reset cs", cs_a | cs_b | cs_c, 1'b0);
    chk("R10 reset ready", bus_ready, 1'b1);
    chk("R11 reset we", mem_we, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // Idle bus: no selects
    cfg_base_a = 3'd0;
    for (int k = 0; k < 16; k++) begin
      drive_addr(probe(k));
      chk("R12 idle", cs_a | cs_b | cs_c | card_oe | mem_we, 1'b0);
    end

    // Read sweep over every base placement and disable combination
    bus_valid = 1'b1;
    bus_write = 1'b0;
    for (int d = 0; d < 8; d++)
      for (int cfg = 0; cfg < 256; cfg++) begin
        {cfg_dis_c, cfg_dis_b, cfg_dis_a} = 3'(d);
        cfg_base_a = 3'(cfg);
        cfg_base_b = 3'(cfg >> 3);
        cfg_base_c = 2'(cfg >> 6);
        for (int k = 0; k < 16; k++) begin
          drive_addr(probe(k));
          e = exp_sel(bus_addr);
          chk("R1 R4 R5 cs_a", cs_a, e[0]);
          chk("R2 R4 R5 cs_b", cs_b, e[1]);
          chk("R3 R4 R5 cs_c", cs_c, e[2]);
          chk("R9 card_oe", card_oe, |e);
        end
      end

    // Named boundaries: A at 000, C at 10
    {cfg_dis_c, cfg_dis_b, cfg_dis_a} = 3'b000;
    cfg_base_a = 3'd0; cfg_base_b = 3'd7; cfg_base_c = 2'b10;
    drive_addr(16'h1FFF); chk("R1 top of A", cs_a, 1'b1);
    drive_addr(16'h2000); chk("R1 past A", cs_a, 1'b0);
    drive_addr(16'h8000); chk("R3 base of C", cs_c, 1'b1);
    drive_addr(16'hBFFF); chk("R3 top of C", cs_c, 1'b1);
    drive_addr(16'h7FFF); chk("R3 below C", cs_c, 1'b0);
    drive_addr(16'hC000); chk("R3 above C", cs_c, 1'b0);

    // Write protection: A=0x0000, B=0x2000, C=0x8000 (halves at bit 13)
    cfg_base_a = 3'd0; cfg_base_b = 3'd1; cfg_base_c = 2'b10;
    bus_write = 1'b1;
    for (int w = 0; w < 16; w++) begin
      {cfg_we_ch, cfg_we_cl, cfg_we_b, cfg_we_a} = 4'(w);
      for (int k = 0; k < 16; k++) begin
        drive_addr(probe(k));
        case (bus_addr >> 13)
          0: we_exp = cfg_we_a;
          1: we_exp = cfg_we_b;
          4: we_exp = cfg_we_cl;
          5: we_exp = cfg_we_ch;
          default: we_exp = 1'b0;
        endcase
        bus_wstb = 1'b0; #1;
        chk("R11 no strobe", mem_we, 1'b0);
        bus_wstb = 1'b1; #1;
        chk("R6 write enable", mem_we, we_exp);
        chk("R9 no oe on write", card_oe, 1'b0);
      end
    end
    bus_wstb = 1'b0;

    // Reads from write-protected banks still select
    bus_write = 1'b0;
    {cfg_we_ch, cfg_we_cl, cfg_we_b, cfg_we_a} = 4'b0000;
    for (int k = 0; k < 16; k++) begin
      drive_addr(probe(k));
      e = exp_sel(bus_addr);
      chk("R7 protected read oe", card_oe, |e);
      chk("R7 protected read cs", cs_a | cs_b | cs_c, |e);
    end

    // Phantom override, reads and writes
    phantom = 1'b1;
    {cfg_we_ch, cfg_we_cl, cfg_we_b, cfg_we_a} = 4'b1111;
    for (int wr = 0; wr < 2; wr++)
      for (int k = 0; k < 16; k++) begin
        bus_write = wr[0];
        bus_wstb  = wr[0];
        drive_addr(probe(k));
        chk("R8 phantom", cs_a | cs_b | cs_c | card_oe | mem_we, 1'b0);
      end
    phantom = 1'b0;
    bus_write = 1'b0;
    bus_wstb = 1'b0;

    // Wait state: hit a write into bank A and hold it
    bus_valid = 1'b0;
    drive_addr(16'h0010);
    cfg_wait = 1'b1;
    bus_write = 1'b1; bus_wstb = 1'b1; bus_valid = 1'b1;
    #1;
    chk("R10 first clock stalled", bus_ready, 1'b0);
    chk("R11 no write while stalled", mem_we, 1'b0);
    @(posedge clk); #1;
    chk("R10 second clock ready", bus_ready, 1'b1);
    chk("R11 write on completion", mem_we, 1'b1);
    @(posedge clk); #1;
    chk("R10 back-to-back hit stalls again", bus_ready, 1'b0);
    @(posedge clk); #1;
    chk("R10 back-to-back completes", bus_ready, 1'b1);
    @(negedge clk);
    bus_addr = 16'h4000;  // miss: no bank there
    #1;
    chk("R10 miss not stalled", bus_ready, 1'b1);
    @(posedge clk); #1;
    chk("R10 miss still ready", bus_ready, 1'b1);
    @(negedge clk);
    bus_valid = 1'b0;
    cfg_wait = 1'b0;
    bus_addr = 16'h0010;
    bus_valid = 1'b1;
    #1;
    chk("R10 no wait when off", bus_ready, 1'b1);
    @(negedge clk);
    bus_valid = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule